// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial line into bytes. A sample-clock enable that pulses sixteen times per bit period drives a small state machine. The machine finds a start edge and rejects it if the line has not stayed low until the middle of the start bit. It then samples 5 to 8 data bits, an optional parity bit and the stop bit at their centres. Each character goes into a 16-entry first-in first-out queue together with three tags of its own: parity error, framing error and line break.

The parallel side reads the queue through a show-ahead pop interface. It also sees four status flags: data present, occupancy at a programmable threshold, dropped character, and idle queue. The first three flags are held back by 3 sample-enable periods when they assert. The idle flag is held back by 8. The flags drop without delay when their cause goes away.

Receiver states: `S_IDLE` (line high, waiting), `S_START` (validating the start bit), `S_DATA` (sampling data bits), `S_PAR` (sampling parity), `S_STOP` (sampling stop and storing), `S_BRKWAIT` (break seen, waiting for the line to go high). Transitions:
- `S_IDLE`→`S_START` on a low sample.
- `S_START`→`S_IDLE` on a false start, or `S_START`→`S_DATA` on a confirmed start.
- `S_DATA`→`S_PAR` or `S_STOP` after the last data bit.
- `S_PAR`→`S_STOP` after the parity sample.
- `S_STOP`→`S_IDLE` after a normal character, or `S_STOP`→`S_BRKWAIT` after a break.
- `S_BRKWAIT`→`S_IDLE` when the line reads high.

Top module: `serial_rx_tagq`

## Requirements
- R1: A frame is one low start bit, then 5+`char_len` data bits least significant first (`char_len` 0..3 gives 5..8), then an optional parity bit, then one stop bit. Bits sampled at each centre are stored right-justified, with the unused upper bits 0.
- R2: With `par_en`=1 the received parity bit is checked: even when `par_odd`=0, odd when `par_odd`=1. A mismatch sets that byte's parity tag (`rd_perr`).
- R3: The queue holds 16 entries in arrival order. `rd_data` and the tags show the oldest entry, and `pop` removes it. A pop while empty has no effect.
- R4: A low level that is not still low at the 8th sample enable after detection is a false start. Nothing is stored.
- R5: A stop bit sampled low sets the framing tag (`rd_ferr`), and the byte is still stored.
- R6: If the data bits, the parity bit (when enabled) and the stop bit all sample 0, exactly one entry is stored. Its data is 0, `rd_brk`=1, `rd_ferr`=1 and `rd_perr`=0. No further entry is stored until the line returns high.
- R7: `data_avail` rises 3 sample-enable periods after the queue turns non-empty. With `samp_en` held high and the start edge driven just before clock edge 0, it is visible after edge 14+16·(data bits+parity bits+1). It drops as soon as the queue is empty.
- R8: `trig_hit` shows occupancy at or above a threshold chosen by `trig_sel` (0:1, 1:4, 2:8, 3:14 entries). It has the same 3-period rise delay as R7.
- R9: A character that arrives while the queue is full is dropped and the stored entries are kept. `overrun` then rises after 3 sample-enable periods, stays set, and clears the cycle after an `ovr_clr` pulse.
- R10: The tags are forced to 0 while `data_avail` is low. The tags of the first byte in an empty queue appear together with `data_avail`. Those of later bytes appear in the cycle right after the previous byte is popped.
- R11: When the queue is non-empty and no push or pop occurs for 4·16·(frame bits) sample enables, `timeout` rises 8 enables later. A pop clears it at once.
- R12: After reset every flag and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_en | input | 1 | Sample enable, 16 per bit period |
| rxd | input | 1 | Serial line input, idle high |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| trig_sel | input | 2 | Threshold select (1/4/8/14) |
| pop | input | 1 | Remove oldest entry |
| ovr_clr | input | 1 | Clear the dropped-character flag |
| rd_data | output | 8 | Oldest byte |
| rd_perr | output | 1 | Parity tag of oldest byte |
| rd_ferr | output | 1 | Framing tag of oldest byte |
| rd_brk | output | 1 | Break tag of oldest byte |
| data_avail | output | 1 | Queue non-empty (delayed) |
| trig_hit | output | 1 | Occupancy at threshold (delayed) |
| overrun | output | 1 | Character dropped (delayed, sticky) |
| timeout | output | 1 | Queue idle too long (delayed) |

## Verification
A sample counter that is off by one shifts every sample point. For the character widths in use, the stored bytes and tags at the ports are then wrong on the very first frame. It also moves the `data_avail` rise away from the cycle that R7 predicts. A queue pointer or count error shows up on the next pop as out-of-order data, a lost entry or a missing overrun, within one pass through 17 characters. A delay counter that is wrong in length moves the exact rise cycle of `data_avail`, `trig_hit` or `timeout`, so those rises are checked to the cycle.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } srx_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BRKWAIT
    } srx_state_t;

    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        logic [4:0] lvl;
        unique case (sel)
            2'd0:    lvl = 5'd1;
            2'd1:    lvl = 5'd4;
            2'd2:    lvl = 5'd8;
            default: lvl = 5'd14;
        endcase
        return lvl;
    endfunction
endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       samp_en,
    input  logic       rxd,
    input  logic [1:0] char_len,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       push,
    output srx_entry_t push_ent
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    logic              sync1, rxs;
    srx_state_t        state, nxt;
    logic [CW-1:0]     cnt;
    logic [2:0]        bidx;
    logic [DATA_W-1:0] shreg;
    logic              parbit;
    logic [3:0]        nbits;
    logic              tick_mid, tick_last, line_brk;

    assign nbits     = 4'd5 + {2'b00, char_len};
    assign tick_mid  = samp_en && (cnt == MID);
    assign tick_last = samp_en && (cnt == LAST);
    assign line_brk  = !rxs && (shreg == '0) && !(par_en && parbit);

    // two-flop synchronizer, idles high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            rxs   <= 1'b1;
        end else begin
            sync1 <= rxd;
            rxs   <= sync1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (samp_en && !rxs) nxt = S_START;
            S_START:   if (tick_mid) nxt = rxs ? S_IDLE : S_DATA;
            S_DATA:    if (tick_last && ({1'b0, bidx} == nbits - 4'd1))
                           nxt = par_en ? S_PAR : S_STOP;
            S_PAR:     if (tick_last) nxt = S_STOP;
            S_STOP:    if (tick_last) nxt = line_brk ? S_BRKWAIT : S_IDLE;
            S_BRKWAIT: if (rxs) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            parbit   <= 1'b0;
            push     <= 1'b0;
            push_ent <= '0;
        end else begin
            push <= 1'b0;
            if (state != nxt) cnt <= '0;
            else if (samp_en) cnt <= cnt + 1'b1;
            unique case (state)
                S_START: begin
                    bidx   <= '0;
                    shreg  <= '0;
                    parbit <= 1'b0;
                end
                S_DATA: if (tick_last) begin
                    shreg[bidx] <= rxs;
                    bidx        <= bidx + 1'b1;
                end
                S_PAR: if (tick_last) parbit <= rxs;
                S_STOP: if (tick_last) begin
                    push          <= 1'b1;
                    push_ent.data <= shreg;
                    push_ent.brk  <= line_brk;
                    push_ent.ferr <= !rxs;
                    push_ent.perr <= par_en && !line_brk && (^shreg ^ parbit ^ par_odd);
                end
                default: ;
            endcase
        end
    end

    // R1: a store only follows a stop-bit sample
    p_push_from_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(state) == S_STOP);

    // R4: a start bit found high at mid-bit sends the machine back to idle
    p_false_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START && tick_mid && rxs) |=> state == S_IDLE);

    // R6: a break entry is all-zero and carries the framing tag
    p_break_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_ent.brk) |-> (push_ent.ferr && push_ent.data == '0 && !push_ent.perr));
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  srx_entry_t wr_ent,
    input  logic       pop,
    output srx_entry_t head,
    output logic [$clog2(DEPTH):0] count,
    output logic       dropped
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

    srx_entry_t    mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign do_pop  = pop && (count != '0);
    assign do_push = push && (count != FULL);
    assign dropped = push && (count == FULL);
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wr_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);

    p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0 && !push) |=> count == '0);

    p_drop_on_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && count == FULL && !pop) |=> (count == FULL && $stable(wptr)));
endmodule

// File: rtl/srx_delay.sv
module srx_delay #(
    parameter int DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_en,
    input  logic raw,
    output logic dly_out
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] LIM = CW'(DLY);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt <= '0;
        else if (!raw)                   cnt <= '0;
        else if (samp_en && cnt != LIM)  cnt <= cnt + 1'b1;
    end

    assign dly_out = raw && (cnt == LIM);

    // R7: a freshly raised condition is never visible in its first cycle
    p_hold_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !$past(raw)) |-> !dly_out);
endmodule

// File: rtl/serial_rx_tagq.sv
module serial_rx_tagq
    import srx_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int DEPTH    = 16,
    parameter int TO_CHARS = 4,
    parameter int STAT_DLY = 3,
    parameter int TO_DLY   = 8,
    parameter int TW       = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       samp_en,
    input  logic       rxd,
    input  logic [1:0] char_len,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic [1:0] trig_sel,
    input  logic       pop,
    input  logic       ovr_clr,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic       data_avail,
    output logic       trig_hit,
    output logic       overrun,
    output logic       timeout
);
    localparam int AW = $clog2(DEPTH);

    logic          push, dropped, ovr_flag, pop_eff, to_raw;
    srx_entry_t    push_ent, head;
    logic [AW:0]   count;
    logic [3:0]    frame_bits;
    logic [TW-1:0] idle_cnt, idle_lim;
    logic [2:0]    stat_raw, stat_out;

    srx_sampler #(.OSR(OSR)) u_sampler (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rxd(rxd),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .push(push), .push_ent(push_ent)
    );

    srx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wr_ent(push_ent),
        .pop(pop), .head(head), .count(count), .dropped(dropped)
    );

    // sticky drop flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovr_flag <= 1'b0;
        else if (dropped) ovr_flag <= 1'b1;
        else if (ovr_clr) ovr_flag <= 1'b0;
    end

    // idle timer: runs while entries wait and nothing moves
    assign pop_eff    = pop && (count != '0);
    assign frame_bits = 4'd7 + {2'b00, char_len} + {3'b000, par_en};
    assign idle_lim   = TW'(TO_CHARS * OSR) * {{(TW-4){1'b0}}, frame_bits};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_cnt <= '0;
        else if (count == '0 || push || pop_eff) idle_cnt <= '0;
        else if (samp_en && idle_cnt != idle_lim) idle_cnt <= idle_cnt + 1'b1;
    end

    assign to_raw = (count != '0) && (idle_cnt == idle_lim);

    assign stat_raw[0] = (count != '0);
    assign stat_raw[1] = (count >= (AW+1)'(trig_level(trig_sel)));
    assign stat_raw[2] = ovr_flag;

    for (genvar g = 0; g < 3; g++) begin : g_stat
        srx_delay #(.DLY(STAT_DLY)) u_dly (
            .clk(clk), .rst_n(rst_n), .samp_en(samp_en),
            .raw(stat_raw[g]), .dly_out(stat_out[g])
        );
    end

    srx_delay #(.DLY(TO_DLY)) u_to_dly (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en),
        .raw(to_raw), .dly_out(timeout)
    );

    assign data_avail = stat_out[0];
    assign trig_hit   = stat_out[1];
    assign overrun    = stat_out[2];
    assign rd_data    = data_avail ? head.data : '0;
    assign rd_perr    = data_avail && head.perr;
    assign rd_ferr    = data_avail && head.ferr;
    assign rd_brk     = data_avail && head.brk;

    // R9: a clear pulse without a new drop empties the flag by the next cycle
    p_ovr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !dropped) |=> !overrun);

    // R11: the idle flag is gone right after a pop
    p_to_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop_eff |=> !timeout);
endmodule

// File: tb/test_serial_rx_tagq.sv
module test_serial_rx_tagq;
    logic clk = 0, rst_n = 0, samp_en = 1, rxd = 1;
    logic [1:0] char_len = 2'd3, trig_sel = 2'd0;
    logic par_en = 0, par_odd = 0, pop = 0, ovr_clr = 0;
    logic [7:0] rd_data;
    logic rd_perr, rd_ferr, rd_brk, data_avail, trig_hit, overrun, timeout;

    int checks = 0, errors = 0, tick = 0;
    bit finished = 0;

    always #10 clk = ~clk;
    always @(posedge clk) tick <= tick + 1;

    serial_rx_tagq i_serial_rx_tagq (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rxd(rxd),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .trig_sel(trig_sel), .pop(pop), .ovr_clr(ovr_clr),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
        .data_avail(data_avail), .trig_hit(trig_hit), .overrun(overrun), .timeout(timeout)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int nbits();
        return 5 + int'(char_len);
    endfunction

    function automatic int exp_rise();
        return 15 + 16 * (nbits() + int'(par_en) + 1);
    endfunction

    // drives one frame, records rise indices of data_avail and trig_hit
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_v,
                              output int t0, output int da_rise, output int tr_rise,
                              output bit perr_early);
        int n = nbits();
        int total = n + int'(par_en) + 2;
        bit pb = (^(d & 8'((1 << n) - 1))) ^ par_odd ^ bad_par;
        bit prev_da = 0, prev_tr = 0;
        da_rise = -1; tr_rise = -1; perr_early = 0; t0 = 0;
        for (int i = 0; i < total * 16; i++) begin
            int b = i / 16;
            @(negedge clk);
            if (i == 0) begin
                t0 = tick; prev_da = data_avail; prev_tr = trig_hit;
            end else begin
                if (!prev_da && data_avail && da_rise < 0) da_rise = i;
                if (!prev_tr && trig_hit && tr_rise < 0) tr_rise = i;
                if (da_rise < 0 && rd_perr) perr_early = 1;
                prev_da = data_avail; prev_tr = trig_hit;
            end
            if (b == 0)                       rxd = 1'b0;
            else if (b <= n)                  rxd = d[b-1];
            else if (par_en && b == n + 1)    rxd = pb;
            else                              rxd = stop_v;
        end
        @(negedge clk);
        rxd = 1'b1;
    endtask

    task automatic send(input logic [7:0] d);
        int t0, dr, tr; bit pe;
        send_frame(d, 0, 1, t0, dr, tr, pe);
    endtask

    task automatic pop_check(input logic [7:0] ed, input bit ep, input bit ef, input bit eb, input string req);
        @(negedge clk);
        chk(data_avail == 1, req, "data_avail before pop", data_avail, 1);
        chk(rd_data == ed, req, "rd_data", rd_data, ed);
        chk({rd_perr, rd_ferr, rd_brk} == {ep, ef, eb}, req, "tags perr/ferr/brk",
            {rd_perr, rd_ferr, rd_brk}, {ep, ef, eb});
        pop = 1;
        @(negedge clk);
        pop = 0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (data_avail) begin
            pop = 1;
            @(negedge clk);
            pop = 0;
        end
        ovr_clr = 1;
        @(negedge clk);
        ovr_clr = 0;
    endtask

    task automatic set_cfg(input logic [1:0] cl, input bit pe, input bit po, input logic [1:0] ts);
        @(negedge clk);
        char_len = cl; par_en = pe; par_odd = po; trig_sel = ts;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk({data_avail, trig_hit, overrun, timeout} == 4'b0, "R12", "flags after reset",
            {data_avail, trig_hit, overrun, timeout}, 0);
        chk(rd_data == 8'h00, "R12", "rd_data after reset", rd_data, 0);
    endtask

    task automatic t_basic();
        int t0, dr, tr; bit pe;
        set_cfg(2'd3, 0, 0, 2'd0);
        send_frame(8'hA7, 0, 1, t0, dr, tr, pe);
        chk(dr == exp_rise(), "R7", "data_avail rise index 8N1", dr, exp_rise());
        chk(tr == exp_rise(), "R8", "trig_hit rise index level 1", tr, exp_rise());
        pop_check(8'hA7, 0, 0, 0, "R1");
        chk(data_avail == 0, "R7", "data_avail after last pop", data_avail, 0);
        pop = 1; @(negedge clk); pop = 0; @(negedge clk);
        chk(data_avail == 0 && trig_hit == 0, "R3", "pop while empty", data_avail, 0);
    endtask

    task automatic t_len_parity();
        int t0, dr, tr; bit pe;
        set_cfg(2'd0, 1, 1, 2'd0);
        send_frame(8'hF5, 0, 1, t0, dr, tr, pe);
        chk(dr == exp_rise(), "R7", "data_avail rise index 5O1", dr, exp_rise());
        pop_check(8'h15, 0, 0, 0, "R1");
        set_cfg(2'd2, 1, 0, 2'd0);
        send_frame(8'h3C, 1, 1, t0, dr, tr, pe);
        send_frame(8'h3C, 0, 1, t0, dr, tr, pe);
        pop_check(8'h3C, 1, 0, 0, "R2");
        pop_check(8'h3C, 0, 0, 0, "R2");
    endtask

    task automatic t_false_start();
        set_cfg(2'd3, 0, 0, 2'd0);
        @(negedge clk); rxd = 0;
        repeat (5) @(negedge clk);
        rxd = 1;
        repeat (200) @(negedge clk);
        chk(data_avail == 0, "R4", "nothing stored after glitch", data_avail, 0);
        send(8'h5A);
        pop_check(8'h5A, 0, 0, 0, "R4");
        chk(data_avail == 0, "R4", "single entry after glitch", data_avail, 0);
    endtask

    task automatic t_framing();
        int t0, dr, tr; bit pe;
        set_cfg(2'd3, 0, 0, 2'd0);
        send_frame(8'hA5, 0, 0, t0, dr, tr, pe);
        repeat (40) @(negedge clk);
        pop_check(8'hA5, 0, 1, 0, "R5");
        chk(data_avail == 0, "R5", "no extra entry after low stop", data_avail, 0);
    endtask

    task automatic t_break();
        set_cfg(2'd2, 1, 1, 2'd0);
        @(negedge clk); rxd = 0;
        repeat (16 * 10 + 64) @(negedge clk);
        rxd = 1;
        repeat (60) @(negedge clk);
        pop_check(8'h00, 0, 1, 1, "R6");
        chk(data_avail == 0, "R6", "one entry per break", data_avail, 0);
    endtask

    task automatic t_trigger();
        int t0, dr, tr; bit pe;
        set_cfg(2'd3, 0, 0, 2'd1);
        for (int k = 0; k < 3; k++) send(8'h10 + 8'(k));
        @(negedge clk);
        chk(trig_hit == 0, "R8", "trig_hit at 3 of 4", trig_hit, 0);
        send_frame(8'h13, 0, 1, t0, dr, tr, pe);
        chk(tr == exp_rise(), "R8", "trig_hit rise index at 4", tr, exp_rise());
        pop_check(8'h10, 0, 0, 0, "R3");
        chk(trig_hit == 0, "R8", "trig_hit after pop to 3", trig_hit, 0);
        drain();
    endtask

    task automatic t_tags();
        int t0, dr, tr; bit pe;
        set_cfg(2'd3, 1, 0, 2'd0);
        send_frame(8'h81, 1, 1, t0, dr, tr, pe);
        chk(dr == exp_rise(), "R10", "first byte data_avail rise", dr, exp_rise());
        chk(pe == 0, "R10", "parity tag visible before data_avail", pe, 0);
        pop_check(8'h81, 1, 0, 0, "R10");
        send(8'h42);
        send_frame(8'h43, 1, 1, t0, dr, tr, pe);
        pop_check(8'h42, 0, 0, 0, "R10");
        chk(rd_perr == 1, "R10", "next byte tag right after pop", rd_perr, 1);
        pop_check(8'h43, 1, 0, 0, "R10");
    endtask

    task automatic t_overrun();
        set_cfg(2'd3, 0, 0, 2'd3);
        for (int k = 0; k < 17; k++) begin
            send(8'h30 + 8'(k));
            if (k == 15) chk(overrun == 0, "R9", "no overrun at 16", overrun, 0);
        end
        @(negedge clk);
        chk(overrun == 1, "R9", "overrun after 17th char", overrun, 1);
        chk(trig_hit == 1, "R8", "trig_hit at 16 of 14", trig_hit, 1);
        for (int k = 0; k < 16; k++) pop_check(8'h30 + 8'(k), 0, 0, 0, "R9");
        chk(data_avail == 0, "R9", "17th char dropped", data_avail, 0);
        chk(overrun == 1, "R9", "overrun sticky", overrun, 1);
        ovr_clr = 1; @(negedge clk); ovr_clr = 0;
        chk(overrun == 0, "R9", "overrun cleared", overrun, 0);
    endtask

    task automatic t_timeout();
        int t0, dr, tr, lim, rise; bit pe;
        set_cfg(2'd3, 0, 0, 2'd0);
        lim  = 4 * 16 * (nbits() + int'(par_en) + 2);
        rise = exp_rise() - 4 + lim + 9;
        send_frame(8'h77, 0, 1, t0, dr, tr, pe);
        while (tick - t0 < rise - 1) @(negedge clk);
        chk(timeout == 0, "R11", "timeout one cycle early", timeout, 0);
        @(negedge clk);
        chk(timeout == 1, "R11", "timeout at expected cycle", timeout, 1);
        pop = 1; @(negedge clk); pop = 0;
        chk(timeout == 0, "R11", "timeout cleared by pop", timeout, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic();
        t_len_parity();
        t_false_start();
        t_framing();
        t_break();
        t_trigger();
        t_tags();
        t_overrun();
        t_timeout();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule